// File: doc/BRIEF.md
# Watchdog-Capable Timer/Counter with Reset Pulse Generator

This block is a 32-bit up-counter placed next to an 8-bit microcontroller core. It advances either once per machine cycle, marked by a one-clock strobe that arrives every twelve oscillator clocks, or on falling edges of an external count pin. Software loads the count one byte at a time. When the count wraps from all ones to zero, the block sets an overflow flag.

In normal mode the overflow also raises an interrupt request. That request is held until software acknowledges it or writes 0 to the flag. In watchdog mode the same overflow does not interrupt. Instead, a small state machine waits for the next machine cycle and then drives a system reset request for a fixed number of machine cycles. The rest of the chip treats that request like a hardware reset, except that internal RAM is left alone. While the pulse is active, the count is held at zero and count writes are ignored.

In power-down mode the machine-cycle strobe stops. Timer counting therefore freezes, but external counting continues. During power-down the pin is checked on every clock rather than once per machine cycle.

The reset state machine has three states. WS_IDLE waits for an overflow. The transition "overflow in watchdog mode" goes to WS_ARM. WS_ARM waits one machine cycle, and the transition "next strobe" goes to WS_PULSE. WS_PULSE asserts the reset request and counts strobes. The transition "last strobe of the pulse" returns to WS_IDLE. A hardware reset returns the machine to WS_IDLE from any state.

Top module: `wdt_timer`

## Requirements
- R1: While `rst_n` is 0, `ovf_flag`, `irq` and `sys_rst` are 0 and the reset state machine is in WS_IDLE.
- R2: With `sel_ext`=0, `run`=1 and `pd`=0, the count advances by one on each clock where `mc_stb` is 1. Starting from value S, `ovf_flag` becomes 1 on the edge of strobe number 2^32−S.
- R3: With `sel_ext`=1 and `pd`=0, `ext_pin` passes through a two-flop synchronizer and is sampled on each `mc_stb` clock. A count is taken when a 1 sample is followed by a 0 sample, so each falling edge on a pin that stays high and low for at least one machine cycle is counted once.
- R4: While `run`=0 the count does not advance, so no overflow occurs.
- R5: An overflow with `wd_en`=0 sets both `ovf_flag` and `irq` to 1.
- R6: `irq_ack`=1 clears `ovf_flag` and `irq`. A flag write (`flag_wr`=1) with `flag_wdata`=0 also clears both. If an overflow occurs in the same clock as a clear, the overflow wins.
- R7: `wr_en`=1 replaces one byte of the count: `wr_sel`=0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24. In a write clock the count does not also increment.
- R8: An overflow with `wd_en`=1 sets `ovf_flag` but not `irq`. `sys_rst` rises on the clock edge of the next `mc_stb` after the overflow strobe, which is 12 clocks later with regular strobes.
- R9: `sys_rst` stays high for exactly RST_LEN (5) strobes, which is 60 clocks. A further overflow does not extend it. While it is high the count is held at 0 and count writes have no effect.
- R10: Driving `rst_n` to 0 during a pulse drops `sys_rst` and clears `ovf_flag` at once.
- R11: With `pd`=1, timer-mode counting stops. External-mode counting samples the synchronized pin on every clock and counts each 1-then-0 sample pair, even when `mc_stb` is absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| mc_stb | input | 1 | One-clock machine-cycle strobe |
| ext_pin | input | 1 | External count input, asynchronous |
| sel_ext | input | 1 | 0 = count machine cycles, 1 = count pin falling edges |
| wd_en | input | 1 | 1 = overflow produces a reset pulse instead of an interrupt |
| run | input | 1 | Count enable |
| pd | input | 1 | Power-down indication |
| wr_en | input | 1 | Count byte write strobe |
| wr_sel | input | SEL_W (2) | Byte index of the write |
| wr_data | input | BYTE_W (8) | Byte written into the count |
| flag_wr | input | 1 | Software write of the overflow flag |
| flag_wdata | input | 1 | Value for the flag write |
| irq_ack | input | 1 | Interrupt acknowledge |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |
| sys_rst | output | 1 | System reset request pulse |

## Verification
The assertions assume that `mc_stb` is a single-clock pulse. They also assume that at least one clock without a strobe separates successive strobes, so that the strobe count the checker keeps during a pulse matches the state machine's count. The bench produces the strobe from a free-running divide-by-12 counter, stops it completely in power-down, and changes `ext_pin` only at clock falling edges. In normal mode each pin level lasts two or more machine cycles. In power-down each level lasts four clocks, so every level is seen by at least one sample.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARM   = 2'd1,
        WS_PULSE = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdt_ext_sampler.sv
module wdt_ext_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic mc_stb,
    input  logic pd,
    output logic fall
);
    logic sync1_q, sync2_q, smp_q;
    logic smp_en;

    // in power-down the strobe is gone: look at the pin on every clock
    assign smp_en = pd | mc_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            smp_q   <= 1'b0;
        end else begin
            sync1_q <= pin;
            sync2_q <= sync1_q;
            if (smp_en) smp_q <= sync2_q;
        end
    end

    assign fall = smp_en & smp_q & ~sync2_q;
endmodule

// File: rtl/wdt_cnt_core.sv
module wdt_cnt_core #(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 8,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              hold_zero,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              ovf_evt
);
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [NBYTES-1:0] byte_hit;

    for (genvar b = 0; b < NBYTES; b++) begin : g_hit
        assign byte_hit[b] = wr_en && (wr_sel == SEL_W'(b));
    end

    always_comb begin
        cnt_d = cnt_q;
        if (hold_zero) begin
            cnt_d = '0;
        end else if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (byte_hit[b]) cnt_d[b*BYTE_W +: BYTE_W] = wr_data;
            end
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ovf_evt = inc && !wr_en && !hold_zero && (&cnt_q);
endmodule

// File: rtl/wdt_rst_fsm.sv
module wdt_rst_fsm
    import wdt_pkg::*;
#(
    parameter int RST_LEN = 5,
    localparam int PCW = $clog2(RST_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_stb,
    input  logic ovf_evt,
    input  logic wd_en,
    output logic sys_rst,
    output logic hold_zero
);
    wd_state_e        state_q, state_d;
    logic [PCW-1:0]   pcnt_q, pcnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        unique case (state_q)
            WS_IDLE: begin
                pcnt_d = '0;
                if (ovf_evt && wd_en) state_d = WS_ARM;
            end
            WS_ARM: begin
                pcnt_d = '0;
                if (mc_stb) state_d = WS_PULSE;
            end
            WS_PULSE: begin
                if (mc_stb) begin
                    if (pcnt_q == PCW'(RST_LEN - 1)) begin
                        state_d = WS_IDLE;
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d = pcnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = WS_IDLE;
                pcnt_d  = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            WS_PULSE: begin
                sys_rst   = 1'b1;
                hold_zero = 1'b1;
            end
            default: begin
                sys_rst   = 1'b0;
                hold_zero = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int CNT_W   = 32,
    parameter int BYTE_W  = 8,
    parameter int RST_LEN = 5,
    localparam int NBYTES = CNT_W / BYTE_W,
    localparam int SEL_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_stb,
    input  logic              ext_pin,
    input  logic              sel_ext,
    input  logic              wd_en,
    input  logic              run,
    input  logic              pd,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    input  logic              irq_ack,
    output logic              ovf_flag,
    output logic              irq,
    output logic              sys_rst
);
    logic ext_fall, inc, ovf_evt, hold_zero;
    logic flag_q, irq_q, sw_clear;

    wdt_ext_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (ext_pin),
        .mc_stb (mc_stb),
        .pd     (pd),
        .fall   (ext_fall)
    );

    assign inc = run && (sel_ext ? ext_fall : (mc_stb && !pd));

    wdt_cnt_core #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .hold_zero (hold_zero),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ovf_evt   (ovf_evt)
    );

    wdt_rst_fsm #(.RST_LEN(RST_LEN)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_stb    (mc_stb),
        .ovf_evt   (ovf_evt),
        .wd_en     (wd_en),
        .sys_rst   (sys_rst),
        .hold_zero (hold_zero)
    );

    assign sw_clear = irq_ack || (flag_wr && !flag_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (ovf_evt)      flag_q <= 1'b1;
            else if (irq_ack) flag_q <= 1'b0;
            else if (flag_wr) flag_q <= flag_wdata;

            if (ovf_evt && !wd_en) irq_q <= 1'b1;
            else if (sw_clear)     irq_q <= 1'b0;
        end
    end

    assign ovf_flag = flag_q;
    assign irq      = irq_q;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
    parameter int RST_LEN = 5,
    localparam int CW = $clog2(RST_LEN + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic mc_stb,
    input logic sel_ext,
    input logic wd_en,
    input logic run,
    input logic pd,
    input logic wr_en,
    input logic irq,
    input logic sys_rst,
    input logic ovf_evt
);
    logic [CW-1:0] stb_in_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stb_in_pulse <= '0;
        else if (!sys_rst) stb_in_pulse <= '0;
        else if (mc_stb)   stb_in_pulse <= stb_in_pulse + 1'b1;
    end

    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !ovf_evt); // R4
    AST_WRITE_PRIO: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !ovf_evt); // R7
    AST_PD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (pd && !sel_ext) |-> !ovf_evt); // R11
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(!wd_en)); // R5
    AST_RST_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst) |-> $past(mc_stb)); // R8
    AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(sys_rst) |-> (stb_in_pulse == CW'(RST_LEN))); // R9
    AST_NO_OVF_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sys_rst |-> !ovf_evt); // R9
endmodule

bind wdt_timer wdt_timer_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mc_stb  (mc_stb),
    .sel_ext (sel_ext),
    .wd_en   (wd_en),
    .run     (run),
    .pd      (pd),
    .wr_en   (wr_en),
    .irq     (irq),
    .sys_rst (sys_rst),
    .ovf_evt (ovf_evt)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mc_stb = 1'b0;
    logic ext_pin = 1'b0;
    logic sel_ext = 1'b0, wd_en = 1'b0, run = 1'b0, pd = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic flag_wr = 1'b0, flag_wdata = 1'b0, irq_ack = 1'b0;
    logic ovf_flag, irq, sys_rst;

    int errors = 0, checks = 0;
    int phase = 0;
    int stb_cnt = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdt_timer dut (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .ext_pin(ext_pin),
        .sel_ext(sel_ext), .wd_en(wd_en), .run(run), .pd(pd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata), .irq_ack(irq_ack),
        .ovf_flag(ovf_flag), .irq(irq), .sys_rst(sys_rst)
    );

    // machine-cycle strobe: one clock in twelve, absent in power-down
    always @(negedge clk) begin
        if (pd) begin
            mc_stb <= 1'b0;
        end else begin
            phase  <= (phase == 11) ? 0 : phase + 1;
            mc_stb <= (phase == 11);
        end
    end

    always @(posedge clk) if (mc_stb) stb_cnt <= stb_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] v);
        run = 1'b0;
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 2'(b); wr_data = v[b*8 +: 8];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        @(negedge clk);
        flag_wr = 1'b0;
    endtask

    task automatic align_strobe();
        do @(posedge clk); while (phase != 11);
        @(negedge clk);
    endtask

    task automatic strobes_to_flag(input int limit, output int n);
        int base;
        base = stb_cnt;
        for (int c = 0; c < limit && !ovf_flag; c++) @(negedge clk);
        n = ovf_flag ? (stb_cnt - base) : -1;
    endtask

    task automatic falls_to_flag(input int nmax, input int hi, input int lo, output int k);
        k = -1;
        for (int i = 1; i <= nmax; i++) begin
            ext_pin = 1'b1;
            repeat (hi) @(negedge clk);
            ext_pin = 1'b0;
            repeat (lo) @(negedge clk);
            if (ovf_flag && k < 0) k = i;
        end
    endtask

    typedef struct packed {
        logic        ext;
        logic [31:0] start;
        logic [15:0] n;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 32'hFFFF_FFFF, 16'd1},
        '{1'b0, 32'hFFFF_FFFB, 16'd5},
        '{1'b0, 32'hFFFF_FFEF, 16'd17},
        '{1'b0, 32'hFFFF_FF00, 16'd256},
        '{1'b1, 32'hFFFF_FFFF, 16'd1},
        '{1'b1, 32'hFFFF_FFFC, 16'd4}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, t, t_flag, t_rst, width, irq_seen;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 flag", int'(ovf_flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 sys_rst", int'(sys_rst), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk: R2 / R3 / R5 / R6 / R7
        foreach (VECS[i]) begin
            sel_ext = VECS[i].ext;
            load(VECS[i].start);
            clear_flag();
            @(negedge clk);
            run = 1'b1;
            if (!VECS[i].ext) begin
                strobes_to_flag(12 * (int'(VECS[i].n) + 4), n);
                check("R2 strobes to overflow", n, int'(VECS[i].n));
            end else begin
                falls_to_flag(int'(VECS[i].n) + 2, 24, 36, n);
                check("R3 falls to overflow", n, int'(VECS[i].n));
            end
            check("R5 irq on overflow", int'(irq), 1);
            run = 1'b0;
            @(negedge clk);
            if (i % 2 == 0) begin
                irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
            end else begin
                flag_wr = 1'b1; flag_wdata = 1'b0; @(negedge clk); flag_wr = 1'b0;
            end
            @(negedge clk);
            check("R6 flag cleared", int'(ovf_flag), 0);
            check("R6 irq cleared", int'(irq), 0);
        end
        sel_ext = 1'b0;

        // R4 run=0 holds the count
        load(32'hFFFF_FFFF);
        repeat (120) @(negedge clk);
        check("R4 no overflow while stopped", int'(ovf_flag), 0);

        // R6 overflow beats acknowledge in the same clock
        align_strobe();
        run = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0; run = 1'b0;
        check("R6 overflow wins flag", int'(ovf_flag), 1);
        check("R6 overflow wins irq", int'(irq), 1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;

        // R7 write in a strobe clock replaces, no increment
        load(32'hFFFF_FF00);
        clear_flag();
        run = 1'b1;
        align_strobe();
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'hFE;
        @(negedge clk);
        wr_en = 1'b0;
        strobes_to_flag(120, n);
        check("R7 write priority strobes", n, 2);
        run = 1'b0;
        clear_flag();

        // R8 / R9 watchdog pulse
        load(32'hFFFF_FFFD);
        wd_en = 1'b1;
        @(negedge clk);
        run = 1'b1;
        t_flag = -1; t_rst = -1; width = 0; irq_seen = 0;
        for (t = 0; t < 400; t++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (irq) irq_seen = 1;
            if (ovf_flag && t_flag < 0) t_flag = t;
            if (sys_rst && t_rst < 0) t_rst = t;
            if (sys_rst) begin
                width++;
                if (width >= 5 && width <= 8) begin
                    wr_en = 1'b1; wr_sel = 2'(width - 5); wr_data = 8'hFF;
                end
            end
            if (t_rst >= 0 && !sys_rst) break;
        end
        wr_en = 1'b0;
        check("R8 reset delay clocks", t_rst - t_flag, 12);
        check("R8 no irq in watchdog mode", irq_seen, 0);
        check("R9 pulse width clocks", width, 60);
        wd_en = 1'b0;
        clear_flag();
        repeat (240) @(negedge clk);
        check("R9 writes ignored in pulse", int'(ovf_flag), 0);

        // R10 hardware reset cuts the pulse
        load(32'hFFFF_FFFF);
        wd_en = 1'b1;
        @(negedge clk);
        run = 1'b1;
        for (int c = 0; c < 100 && !sys_rst; c++) @(negedge clk);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 sys_rst dropped", int'(sys_rst), 0);
        check("R10 flag cleared", int'(ovf_flag), 0);
        rst_n = 1'b1;
        width = 0;
        repeat (80) begin @(negedge clk); if (sys_rst) width++; end
        check("R10 no resumed pulse", width, 0);
        run = 1'b0; wd_en = 1'b0;

        // R11 power-down
        pd = 1'b1;
        load(32'hFFFF_FFFF);
        clear_flag();
        run = 1'b1;
        repeat (100) @(negedge clk);
        check("R11 timer frozen", int'(ovf_flag), 0);
        run = 1'b0;
        sel_ext = 1'b1;
        load(32'hFFFF_FFFD);
        clear_flag();
        run = 1'b1;
        falls_to_flag(5, 4, 4, n);
        check("R11 external counting in power-down", n, 3);
        run = 1'b0; pd = 1'b0; sel_ext = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule